// File: doc/BRIEF.md
# Transmit Buffer Status Tracker

This block keeps the transmit bookkeeping for a CAN controller with a bank of dedicated transmit buffers, 32 by default. Software raises a per-buffer request strobe to queue a buffer and a per-buffer cancel strobe to withdraw one. The protocol engine reports each finished frame as a one-cycle pulse carrying the buffer number. For every buffer the block holds a pending flag, a sent flag, a cancel-finished flag, an interrupt enable bit and an interrupt pending bit. The interrupt pending bits are cleared by writing 1.

A sent flag is sticky. It drops only when the same buffer is queued again, so reading the status vector does not by itself show which buffer finished last. To cover that, the block keeps a hardware register with the number of the most recently finished buffer and a valid bit. The valid bit drops once that buffer is queued again. A single interrupt line is the OR of all interrupt pending bits.

Top module: `txBufTracker`

## Requirements
- R1: During and right after reset, every per-buffer flag, every enable bit, every interrupt pending bit, `lastValid` and `irq` are 0. Bit i of every per-buffer vector belongs to buffer i.
- R2: A request strobe on buffer i (`addReq[i]`=1) makes `pendingReq[i]`=1, `occurred[i]`=0 and `cancelDone[i]`=0 in the following cycle.
- R3: A completion pulse (`doneValid`=1, `doneIdx`=i) with no request on buffer i in the same cycle makes `occurred[i]`=1 and `pendingReq[i]`=0 in the following cycle.
- R4: Once set, `occurred[i]` stays 1 through idle cycles, through cancels and through completions of other buffers, until a request on buffer i arrives.
- R5: A cancel strobe on a pending buffer i, with no request and no completion for i in that cycle, makes `cancelDone[i]`=1 and `pendingReq[i]`=0 and leaves `occurred[i]` unchanged. A cancel on a buffer that is not pending changes nothing.
- R6: With `ieWrEn`=1, `intEnable` takes the value of `ieWrData` in the next cycle. Otherwise `intEnable` keeps its value.
- R7: A completion as in R3 sets `intPending[i]` in the next cycle if `intEnable[i]` was 1 in the cycle of the pulse. A 1 in `irqClr[i]` clears `intPending[i]`, but a set in the same cycle takes priority over the clear. `irq` is 1 exactly when some `intPending` bit is 1.
- R8: On every completion pulse, `lastIdx` takes `doneIdx` in the next cycle. `lastValid` becomes 1 unless the same buffer is requested in that same cycle.
- R9: When `lastValid`=1 and buffer `lastIdx` is requested with no completion pulse in that cycle, `lastValid` is 0 in the next cycle.
- R10: When a request and a completion hit the same buffer in the same cycle, the request wins: `occurred` ends at 0, `pendingReq` at 1, and no interrupt pending bit is set. A request together with a cancel on the same buffer also gives the result of R2.
- R11: `txSuccess[i]` is 1 exactly when `occurred[i]`=1 and `cancelDone[i]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addReq | input | NUM_BUF | Per-buffer transmit request strobes |
| cancelReq | input | NUM_BUF | Per-buffer cancel request strobes |
| doneValid | input | 1 | Completion pulse from the protocol engine |
| doneIdx | input | IDX_W | Buffer number of the completed frame |
| ieWrEn | input | 1 | Write strobe for the interrupt enable register |
| ieWrData | input | NUM_BUF | New interrupt enable value |
| irqClr | input | NUM_BUF | Write-1-to-clear mask for interrupt pending bits |
| pendingReq | output | NUM_BUF | Request pending per buffer |
| occurred | output | NUM_BUF | Transmission-occurred flags (sticky) |
| cancelDone | output | NUM_BUF | Cancellation-finished flags |
| txSuccess | output | NUM_BUF | Sent and not cancelled |
| intEnable | output | NUM_BUF | Interrupt enable register |
| intPending | output | NUM_BUF | Interrupt pending register |
| irq | output | 1 | Interrupt line |
| lastIdx | output | IDX_W | Number of the most recently completed buffer |
| lastValid | output | 1 | `lastIdx` refers to a completion not yet requeued |

## Verification
The bench builds the tracker with four buffers and a two-bit index. With that size, every mix of request, cancel and completion on one buffer can be swept from both a pending and an idle start. The same small size makes random traffic collide often: a completion lands on the buffer named by `lastIdx` just as it is requeued, and interrupt set and clear meet on one bit. A behavioural model built from the requirements predicts every output in every cycle.

// File: rtl/txbt_pkg.sv
package txbt_pkg;

  // per-buffer update strobes issued by the control to the datapath
  typedef struct packed {
    logic start;   // new request: pending on, flags off
    logic finish;  // frame sent and not overridden by a request
    logic abort;   // cancel accepted
    logic raise;   // completion on an enabled buffer
  } bufStrobe_t;

  // strobes for the last-completed-index register
  typedef struct packed {
    logic update;    // load doneIdx
    logic newValid;  // valid value to load with it
    logic kill;      // requeue of the recorded buffer
  } lastStrobe_t;

endpackage

// File: rtl/txbtCtrl.sv
module txbtCtrl
  import txbt_pkg::*;
#(
  parameter int NUM_BUF = 32,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_BUF-1:0] addReq,
  input  logic [NUM_BUF-1:0] cancelReq,
  input  logic               doneValid,
  input  logic [IDX_W-1:0]   doneIdx,
  input  logic [NUM_BUF-1:0] pendingReq,
  input  logic [NUM_BUF-1:0] intEnable,
  input  logic               lastValid,
  input  logic [IDX_W-1:0]   lastIdx,
  output bufStrobe_t [NUM_BUF-1:0] bufStb,
  output lastStrobe_t        lastStb
);

  localparam logic [IDX_W:0] NUM_LIM = (IDX_W+1)'(NUM_BUF);

  logic idxInRange;
  assign idxInRange = ({1'b0, doneIdx} < NUM_LIM);

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic doneHit;
    assign doneHit = doneValid && (doneIdx == IDX_W'(i));

    always_comb begin
      bufStb[i].start  = addReq[i];
      bufStb[i].finish = doneHit && !addReq[i];
      bufStb[i].abort  = cancelReq[i] && pendingReq[i] && !addReq[i] && !doneHit;
      bufStb[i].raise  = doneHit && !addReq[i] && intEnable[i];
    end
  end

  always_comb begin
    lastStb.update   = doneValid && idxInRange;
    lastStb.newValid = !addReq[doneIdx];
    lastStb.kill     = lastValid && addReq[lastIdx];
  end

endmodule

// File: rtl/txbtStatusRegs.sv
module txbtStatusRegs
  import txbt_pkg::*;
#(
  parameter int NUM_BUF = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  bufStrobe_t [NUM_BUF-1:0] bufStb,
  input  lastStrobe_t        lastStb,
  input  logic [IDX_W-1:0]   doneIdx,
  input  logic               ieWrEn,
  input  logic [NUM_BUF-1:0] ieWrData,
  input  logic [NUM_BUF-1:0] irqClr,
  output logic [NUM_BUF-1:0] pendingReq,
  output logic [NUM_BUF-1:0] occurred,
  output logic [NUM_BUF-1:0] cancelDone,
  output logic [NUM_BUF-1:0] intEnable,
  output logic [NUM_BUF-1:0] intPending,
  output logic [IDX_W-1:0]   lastIdx,
  output logic               lastValid
);

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_flag
    logic pendQ, occQ, canQ, ipQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ <= 1'b0;
        occQ  <= 1'b0;
        canQ  <= 1'b0;
        ipQ   <= 1'b0;
      end else begin
        if (bufStb[i].start) begin
          pendQ <= 1'b1;
          occQ  <= 1'b0;
          canQ  <= 1'b0;
        end else if (bufStb[i].finish) begin
          pendQ <= 1'b0;
          occQ  <= 1'b1;
        end else if (bufStb[i].abort) begin
          pendQ <= 1'b0;
          canQ  <= 1'b1;
        end
        if (bufStb[i].raise)  ipQ <= 1'b1;
        else if (irqClr[i])   ipQ <= 1'b0;
      end
    end

    assign pendingReq[i] = pendQ;
    assign occurred[i]   = occQ;
    assign cancelDone[i] = canQ;
    assign intPending[i] = ipQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) intEnable <= '0;
    else if (ieWrEn) intEnable <= ieWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastIdx   <= '0;
      lastValid <= 1'b0;
    end else if (lastStb.update) begin
      lastIdx   <= doneIdx;
      lastValid <= lastStb.newValid;
    end else if (lastStb.kill) begin
      lastValid <= 1'b0;
    end
  end

endmodule

// File: rtl/txBufTracker.sv
module txBufTracker
  import txbt_pkg::*;
#(
  parameter int NUM_BUF = 32,
  parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] addReq,
  input  logic [NUM_BUF-1:0] cancelReq,
  input  logic               doneValid,
  input  logic [IDX_W-1:0]   doneIdx,
  input  logic               ieWrEn,
  input  logic [NUM_BUF-1:0] ieWrData,
  input  logic [NUM_BUF-1:0] irqClr,
  output logic [NUM_BUF-1:0] pendingReq,
  output logic [NUM_BUF-1:0] occurred,
  output logic [NUM_BUF-1:0] cancelDone,
  output logic [NUM_BUF-1:0] txSuccess,
  output logic [NUM_BUF-1:0] intEnable,
  output logic [NUM_BUF-1:0] intPending,
  output logic               irq,
  output logic [IDX_W-1:0]   lastIdx,
  output logic               lastValid
);

  bufStrobe_t [NUM_BUF-1:0] bufStb;
  lastStrobe_t              lastStb;

  txbtCtrl #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_ctrl (
    .addReq     (addReq),
    .cancelReq  (cancelReq),
    .doneValid  (doneValid),
    .doneIdx    (doneIdx),
    .pendingReq (pendingReq),
    .intEnable  (intEnable),
    .lastValid  (lastValid),
    .lastIdx    (lastIdx),
    .bufStb     (bufStb),
    .lastStb    (lastStb)
  );

  txbtStatusRegs #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .bufStb     (bufStb),
    .lastStb    (lastStb),
    .doneIdx    (doneIdx),
    .ieWrEn     (ieWrEn),
    .ieWrData   (ieWrData),
    .irqClr     (irqClr),
    .pendingReq (pendingReq),
    .occurred   (occurred),
    .cancelDone (cancelDone),
    .intEnable  (intEnable),
    .intPending (intPending),
    .lastIdx    (lastIdx),
    .lastValid  (lastValid)
  );

  assign irq       = |intPending;
  assign txSuccess = occurred & ~cancelDone;

endmodule

// File: rtl/txbtChecker.sv
module txbtChecker #(
  parameter int NUM_BUF = 32,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_BUF-1:0] addReq,
  input logic [NUM_BUF-1:0] cancelReq,
  input logic               doneValid,
  input logic [IDX_W-1:0]   doneIdx,
  input logic [NUM_BUF-1:0] pendingReq,
  input logic [NUM_BUF-1:0] occurred,
  input logic [NUM_BUF-1:0] cancelDone,
  input logic [NUM_BUF-1:0] intEnable,
  input logic [NUM_BUF-1:0] intPending,
  input logic [IDX_W-1:0]   lastIdx,
  input logic               lastValid
);

  // R2
  req_clears_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addReq != '0) |=> (((occurred | cancelDone) & $past(addReq)) == '0) &&
                       ((pendingReq & $past(addReq)) == $past(addReq)));

  // R3
  done_sets_occ_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !addReq[doneIdx]) |=> occurred[$past(doneIdx)]);

  // R4
  occ_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(occurred) & ~occurred & ~$past(addReq)) == '0));

  // R5
  cancel_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((cancelDone & ~$past(cancelDone) & ~$past(cancelReq)) == '0));

  // R7
  ip_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((intPending & ~$past(intPending) & ~$past(intEnable)) == '0));

  // R8
  last_idx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (lastIdx == $past(doneIdx)));

  // R9
  last_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastValid && addReq[lastIdx] && !doneValid) |=> !lastValid);

endmodule

bind txBufTracker txbtChecker #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addReq     (addReq),
  .cancelReq  (cancelReq),
  .doneValid  (doneValid),
  .doneIdx    (doneIdx),
  .pendingReq (pendingReq),
  .occurred   (occurred),
  .cancelDone (cancelDone),
  .intEnable  (intEnable),
  .intPending (intPending),
  .lastIdx    (lastIdx),
  .lastValid  (lastValid)
);

// File: tb/test_txBufTracker.sv
module test_txBufTracker;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NB-1:0] addReq = '0, cancelReq = '0, ieWrData = '0, irqClr = '0;
  logic doneValid = 1'b0, ieWrEn = 1'b0;
  logic [IW-1:0] doneIdx = '0;
  logic [NB-1:0] pendingReq, occurred, cancelDone, txSuccess, intEnable, intPending;
  logic irq, lastValid;
  logic [IW-1:0] lastIdx;

  // behavioural model state
  logic [NB-1:0] mPend = '0, mOcc = '0, mCan = '0, mIe = '0, mIp = '0;
  logic [IW-1:0] mIdx = '0;
  logic mVal = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txBufTracker #(.NUM_BUF(NB), .IDX_W(IW)) i_txBufTracker (
    .clk(clk), .rstN(rstN), .addReq(addReq), .cancelReq(cancelReq),
    .doneValid(doneValid), .doneIdx(doneIdx), .ieWrEn(ieWrEn),
    .ieWrData(ieWrData), .irqClr(irqClr), .pendingReq(pendingReq),
    .occurred(occurred), .cancelDone(cancelDone), .txSuccess(txSuccess),
    .intEnable(intEnable), .intPending(intPending), .irq(irq),
    .lastIdx(lastIdx), .lastValid(lastValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R2 pendingReq", 32'(pendingReq), 32'(mPend));
    chk("R3 occurred", 32'(occurred), 32'(mOcc));
    chk("R5 cancelDone", 32'(cancelDone), 32'(mCan));
    chk("R6 intEnable", 32'(intEnable), 32'(mIe));
    chk("R7 intPending", 32'(intPending), 32'(mIp));
    chk("R7 irq", 32'(irq), 32'(mIp != '0));
    chk("R11 txSuccess", 32'(txSuccess), 32'(mOcc & ~mCan));
    chk("R9 lastValid", 32'(lastValid), 32'(mVal));
    if (mVal) chk("R8 lastIdx", 32'(lastIdx), 32'(mIdx));
  endtask

  // called at a falling edge: applies inputs for one cycle, advances the
  // model by the requirement rules, then samples at the next falling edge
  task automatic drive(input logic [NB-1:0] a, input logic [NB-1:0] c,
                       input logic dv, input logic [IW-1:0] di,
                       input logic ieW, input logic [NB-1:0] ieD,
                       input logic [NB-1:0] clr);
    logic [NB-1:0] nPend, nOcc, nCan, nIe, nIp;
    logic [IW-1:0] nIdx;
    logic nVal;
    addReq = a; cancelReq = c; doneValid = dv; doneIdx = di;
    ieWrEn = ieW; ieWrData = ieD; irqClr = clr;
    nPend = mPend; nOcc = mOcc; nCan = mCan; nIp = mIp;
    for (int i = 0; i < NB; i++) begin
      logic hit, setIp;
      hit = dv && (int'(di) == i);
      setIp = 1'b0;
      if (a[i]) begin
        nPend[i] = 1'b1; nOcc[i] = 1'b0; nCan[i] = 1'b0;
      end else if (hit) begin
        nPend[i] = 1'b0; nOcc[i] = 1'b1; setIp = mIe[i];
      end else if (c[i] && mPend[i]) begin
        nPend[i] = 1'b0; nCan[i] = 1'b1;
      end
      if (setIp) nIp[i] = 1'b1;
      else if (clr[i]) nIp[i] = 1'b0;
    end
    nIe = ieW ? ieD : mIe;
    nIdx = mIdx; nVal = mVal;
    if (dv) begin
      nIdx = di; nVal = !a[di];
    end else if (mVal && a[mIdx]) begin
      nVal = 1'b0;
    end
    @(negedge clk);
    mPend = nPend; mOcc = nOcc; mCan = nCan; mIe = nIe; mIp = nIp;
    mIdx = nIdx; mVal = nVal;
    compareAll();
  endtask

  task automatic idle();
    drive('0, '0, 1'b0, '0, 1'b0, '0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 flags", 32'({pendingReq, occurred, cancelDone, intEnable, intPending}), 32'd0);
    chk("R1 irq/lastValid", 32'({irq, lastValid}), 32'd0);
    rstN = 1'b1;
    idle();

    // R6: enable buffers 1 and 2
    drive('0, '0, 1'b0, '0, 1'b1, 4'b0110, '0);
    // R2: queue buffers 1 and 3
    drive(4'b1010, '0, 1'b0, '0, 1'b0, '0, '0);
    // R3/R7/R8: buffer 1 completes
    drive('0, '0, 1'b1, 2'd1, 1'b0, '0, '0);
    chk("R7 irq after enabled completion", 32'(irq), 32'd1);
    // R4: hold through idle, a cancel and another completion
    idle();
    drive('0, 4'b0010, 1'b1, 2'd3, 1'b0, '0, '0);
    chk("R4 occurred[1] sticky", 32'(occurred[1]), 32'd1);
    chk("R7 no interrupt for disabled buffer 3", 32'(intPending[3]), 32'd0);
    // R7: set wins over clear, then clear
    drive(4'b0100, '0, 1'b0, '0, 1'b0, '0, '0);
    drive('0, '0, 1'b1, 2'd2, 1'b0, '0, 4'b0100);
    chk("R7 set over clear", 32'(intPending[2]), 32'd1);
    drive('0, '0, 1'b0, '0, 1'b0, '0, 4'b0110);
    chk("R7 cleared", 32'(irq), 32'd0);
    // R9: requeue recorded buffer 2
    drive(4'b0100, '0, 1'b0, '0, 1'b0, '0, '0);
    chk("R9 lastValid dropped", 32'(lastValid), 32'd0);
    // R5: cancel pending buffer 2, ignored cancel on idle buffer 0
    drive('0, 4'b0101, 1'b0, '0, 1'b0, '0, '0);
    chk("R5 cancel pending", 32'({cancelDone[2], pendingReq[2], cancelDone[0]}), 32'b100);
    // R10: request and completion on buffer 1 together
    drive(4'b0010, '0, 1'b1, 2'd1, 1'b0, '0, '0);
    chk("R10 request wins", 32'({occurred[1], pendingReq[1], intPending[1], lastValid}), 32'b0100);

    // near-exhaustive sweep: each buffer, pending or idle, all 8 mixes
    for (int b = 0; b < NB; b++) begin
      for (int pre = 0; pre < 2; pre++) begin
        for (int mix = 0; mix < 8; mix++) begin
          logic [NB-1:0] one;
          one = NB'(1) << b;
          if (pre == 1) drive(one, '0, 1'b0, '0, 1'b0, '0, '0);
          else drive('0, one, 1'b1, IW'(b), 1'b1, NB'(b*5 + mix), '0);
          drive(mix[0] ? one : '0, mix[1] ? one : '0, mix[2], IW'(b), 1'b0, '0,
                mix[0] ? '0 : one);
          idle();
        end
      end
    end

    // random traffic, R1..R11 via the model
    for (int n = 0; n < 3000; n++) begin
      logic [NB-1:0] a, c, clr, ied;
      a = '0; c = '0; clr = '0;
      for (int i = 0; i < NB; i++) begin
        a[i] = ($urandom % 7) == 0;
        c[i] = ($urandom % 5) == 0;
        clr[i] = ($urandom % 6) == 0;
      end
      ied = NB'($urandom);
      drive(a, c, ($urandom % 2) == 0, IW'($urandom), ($urandom % 9) == 0, ied, clr);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule